// File: doc/BRIEF.md
# Justification Gated Clock Controller

This block turns the channel address carried in each bit slot of a time-division multiplexer frame into a one-cycle enable strobe for that channel. It does this by decoding the 4-bit address to one of fifteen outputs. Address zero marks an idle slot and yields nothing. On top of that normal path, the block adjusts the clock rate of one channel per minor frame, which is how bit-stuffing justification is done. It can add one strobe for that channel, or drop one.

The channel to be serviced is captured in a two-stage overhead address pipeline. The first stage is wiped near the end of every minor frame. It is refilled only when the frame sequencer flags that the minor frame belongs to a used port. The first stage is driven out as an interrogation address. A channel-buffer responder answers with a positive request, a negative request, or neither. When the minor frame turns over, the first stage moves into the second stage and the answer is latched as a single pending action. A pending insert steers the decoder to the second-stage address in the first bit of the following word. A pending delete suppresses the next normal slot that carries the second-stage address. Either action clears itself once it has been applied.

Top module: `stuff_gclk_ctrl`

## Requirements
- R1: While `rst_n` is low at a clock edge, all fifteen `gclk` bits and `ovh_addr` are zero after that edge.
- R2: Suppose a slot arrives with `slot_valid` high and a nonzero `chan_addr` value A, and no insert or delete acts in that cycle. Then in the next cycle exactly `gclk[A-1]` is high and every other bit is low.
- R3: A slot with `slot_valid` low, or with `chan_addr` equal to 0, gives all-zero `gclk` in the next cycle, except in an insert cycle (R6).
- R4: `end_of_scan` high in word 27 clears `ovh_addr` to 0 in the next cycle.
- R5: `port_match` high in word 28 loads `chan_addr` into `ovh_addr` in the next cycle. Outside word 28, `port_match` has no effect. In every other case `ovh_addr` holds its value.
- R6: Suppose `pos_req` is high when `end_of_scan` is high in word 28, and `ovh_addr` is nonzero at that time. Then in bit 0 of word 29 the strobe goes to that captured channel, replacing whatever that slot carries. This happens once only.
- R7: Suppose `neg_req` is high (and `pos_req` is low) when `end_of_scan` is high in word 28, and `ovh_addr` is nonzero at that time. Then the next valid slot carrying that captured channel produces no strobe. Later slots and other channels are unaffected. The pending delete is dropped at the next turnover if it has not been used.
- R8: Requests seen at turnover while `ovh_addr` is 0 are ignored. If both requests are high together, the insert wins. At most one action is taken per minor frame.
- R9: In bit 0 of word 29, when no insert is pending, the slot is decoded as a normal slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rst_n | input | 1 | Synchronous reset, active low |
| slot_valid | input | 1 | A channel address is present this cycle |
| chan_addr | input | 4 | Channel address of the current slot |
| word_idx | input | 5 | Word number within the minor frame (0 to 31) |
| bit_idx | input | 3 | Bit number within the word |
| end_of_scan | input | 1 | One-cycle marker on the last bit of each word |
| port_match | input | 1 | The minor frame services a used port |
| pos_req | input | 1 | Responder asks to insert a strobe |
| neg_req | input | 1 | Responder asks to delete a strobe |
| ovh_addr | output | 4 | Interrogation address (first overhead stage) |
| gclk | output | 15 | One-hot strobes; bit k serves channel k+1 |

## Verification
The assertions take for granted three things about the inputs. First, `end_of_scan` marks a single cycle per word. Second, word and bit numbers advance in frame order. Third, `port_match` is not raised on the turnover cycle itself. The bench generates its timing as whole frames of 32 words of 8 bits, with `end_of_scan` only on bit 7. It raises `port_match` only in bit 3. Its responder reads `ovh_addr` to decide on requests. Directed frames deliberately break the responder's usual manners: both requests at once, requests against address 0, and `port_match` outside word 28.

// File: rtl/stuff_gclk_pkg.sv
// Shared types for the justification gated clock controller.
// Assumes: one stuff action at most is pending at any time.
package stuff_gclk_pkg;

    // Action latched at minor frame turnover.
    typedef enum logic [1:0] {
        ACT_NONE = 2'd0,
        ACT_INS  = 2'd1,
        ACT_DEL  = 2'd2
    } stuff_act_e;

endpackage

// File: rtl/stuff_ovh_pipe.sv
// Overhead address pipeline: stage 1 (interrogation address) and
// stage 2 (address being acted on), plus the pending stuff action.
// Assumes end_of_scan marks one cycle per word and that the selector
// reports ins_done/del_done only while the matching action is pending.
module stuff_ovh_pipe
    import stuff_gclk_pkg::*;
#(
    parameter int ADDR_W  = 4,
    parameter int WORD_W  = 5,
    parameter int W_CLEAR = 27,
    parameter int W_LOAD  = 28
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [WORD_W-1:0] word_idx,
    input  logic              end_of_scan,
    input  logic              port_match,
    input  logic [ADDR_W-1:0] chan_addr,
    input  logic              pos_req,
    input  logic              neg_req,
    input  logic              ins_done,
    input  logic              del_done,
    output logic [ADDR_W-1:0] oh1_q,
    output logic [ADDR_W-1:0] oh2_q,
    output stuff_act_e        pend_q
);

    logic clr_hit;
    logic load_hit;
    logic xfer_hit;

    // Decode the word-level timing events that steer the pipeline.
    always_comb begin
        clr_hit  = end_of_scan && (word_idx == WORD_W'(W_CLEAR));
        load_hit = port_match  && (word_idx == WORD_W'(W_LOAD));
        xfer_hit = end_of_scan && (word_idx == WORD_W'(W_LOAD));
    end

    // Stage 1: wiped late in each frame, refilled for a used port.
    always_ff @(posedge clk) begin
        if (!rst_n)        oh1_q <= '0;
        else if (clr_hit)  oh1_q <= '0;
        else if (load_hit) oh1_q <= chan_addr;
    end

    // Stage 2: takes stage 1 at minor frame turnover.
    always_ff @(posedge clk) begin
        if (!rst_n)        oh2_q <= '0;
        else if (xfer_hit) oh2_q <= oh1_q;
    end

    // Pending action: latched at turnover, insert first; self-clearing.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= ACT_NONE;
        end else if (xfer_hit) begin
            if (oh1_q == '0)  pend_q <= ACT_NONE;
            else if (pos_req) pend_q <= ACT_INS;
            else if (neg_req) pend_q <= ACT_DEL;
            else              pend_q <= ACT_NONE;
        end else if (ins_done || del_done) begin
            pend_q <= ACT_NONE;
        end
    end

endmodule

// File: rtl/stuff_addr_sel.sv
// Decoder input selector: picks the slot address or the stage-2
// overhead address, and applies a pending deletion by comparison.
// Assumes pend_act is ACT_INS only with a nonzero oh2_addr.
module stuff_addr_sel
    import stuff_gclk_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int WORD_W = 5,
    parameter int BIT_W  = 3,
    parameter int W_INS  = 29
) (
    input  logic [WORD_W-1:0] word_idx,
    input  logic [BIT_W-1:0]  bit_idx,
    input  logic              slot_valid,
    input  logic [ADDR_W-1:0] chan_addr,
    input  logic [ADDR_W-1:0] oh2_addr,
    input  stuff_act_e        pend_act,
    output logic [ADDR_W-1:0] sel_addr,
    output logic              fire,
    output logic              ins_done,
    output logic              del_done
);

    logic ins_slot;
    logic live_slot;
    logic hit_del;

    // Classify the current cycle for the selector.
    always_comb begin
        ins_slot  = (word_idx == WORD_W'(W_INS)) && (bit_idx == '0);
        live_slot = slot_valid && (chan_addr != '0);
        hit_del   = (pend_act == ACT_DEL) && live_slot && (chan_addr == oh2_addr);
    end

    // Choose the decoder source and report which action was consumed.
    always_comb begin
        sel_addr = chan_addr;
        fire     = 1'b0;
        ins_done = 1'b0;
        del_done = 1'b0;
        if ((pend_act == ACT_INS) && ins_slot) begin
            sel_addr = oh2_addr;
            fire     = 1'b1;
            ins_done = 1'b1;
        end else if (hit_del) begin
            del_done = 1'b1;
        end else if (live_slot) begin
            fire = 1'b1;
        end
    end

endmodule

// File: rtl/stuff_onehot_dec.sv
// Registered one-of-N decoder producing single-cycle channel strobes.
// Assumes address 0 is idle; output bit k serves channel k+1.
module stuff_onehot_dec #(
    parameter int ADDR_W = 4,
    parameter int N_CH   = (1 << ADDR_W) - 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fire,
    input  logic [ADDR_W-1:0] sel_addr,
    output logic [N_CH-1:0]   strobe_q
);

    for (genvar g = 0; g < N_CH; g++) begin : g_ch
        // One flop per channel: set when the selected address is g+1.
        always_ff @(posedge clk) begin
            if (!rst_n) strobe_q[g] <= 1'b0;
            else        strobe_q[g] <= fire && (sel_addr == ADDR_W'(g + 1));
        end
    end

endmodule

// File: rtl/stuff_gclk_ctrl.sv
// Top: per-channel gated clock strobes with one-pulse insert/delete
// per minor frame for justification. Assumes frame timing inputs
// come from a sequencer that marks one end_of_scan per word.
module stuff_gclk_ctrl
    import stuff_gclk_pkg::*;
#(
    parameter int ADDR_W  = 4,
    parameter int WORD_W  = 5,
    parameter int BIT_W   = 3,
    parameter int W_CLEAR = 27,
    parameter int W_LOAD  = 28,
    localparam int N_CH   = (1 << ADDR_W) - 1,
    localparam int W_INS  = W_LOAD + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              slot_valid,
    input  logic [ADDR_W-1:0] chan_addr,
    input  logic [WORD_W-1:0] word_idx,
    input  logic [BIT_W-1:0]  bit_idx,
    input  logic              end_of_scan,
    input  logic              port_match,
    input  logic              pos_req,
    input  logic              neg_req,
    output logic [ADDR_W-1:0] ovh_addr,
    output logic [N_CH-1:0]   gclk
);

    logic [ADDR_W-1:0] oh1_q;
    logic [ADDR_W-1:0] oh2_q;
    stuff_act_e        pend_act;
    logic [ADDR_W-1:0] sel_addr;
    logic              fire;
    logic              ins_done;
    logic              del_done;

    stuff_ovh_pipe #(
        .ADDR_W(ADDR_W), .WORD_W(WORD_W),
        .W_CLEAR(W_CLEAR), .W_LOAD(W_LOAD)
    ) i_pipe (
        .clk(clk), .rst_n(rst_n), .word_idx(word_idx),
        .end_of_scan(end_of_scan), .port_match(port_match),
        .chan_addr(chan_addr), .pos_req(pos_req), .neg_req(neg_req),
        .ins_done(ins_done), .del_done(del_done),
        .oh1_q(oh1_q), .oh2_q(oh2_q), .pend_q(pend_act)
    );

    stuff_addr_sel #(
        .ADDR_W(ADDR_W), .WORD_W(WORD_W), .BIT_W(BIT_W), .W_INS(W_INS)
    ) i_sel (
        .word_idx(word_idx), .bit_idx(bit_idx), .slot_valid(slot_valid),
        .chan_addr(chan_addr), .oh2_addr(oh2_q), .pend_act(pend_act),
        .sel_addr(sel_addr), .fire(fire),
        .ins_done(ins_done), .del_done(del_done)
    );

    stuff_onehot_dec #(
        .ADDR_W(ADDR_W), .N_CH(N_CH)
    ) i_dec (
        .clk(clk), .rst_n(rst_n), .fire(fire),
        .sel_addr(sel_addr), .strobe_q(gclk)
    );

    // Interrogation address is stage 1 of the overhead pipeline.
    always_comb ovh_addr = oh1_q;

endmodule

// File: rtl/stuff_gclk_chk.sv
// Assertion checker bound to stuff_gclk_ctrl.
module stuff_gclk_chk
    import stuff_gclk_pkg::*;
#(
    parameter int ADDR_W  = 4,
    parameter int WORD_W  = 5,
    parameter int BIT_W   = 3,
    parameter int W_CLEAR = 27,
    parameter int W_LOAD  = 28,
    localparam int N_CH   = (1 << ADDR_W) - 1,
    localparam int W_INS  = W_LOAD + 1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              slot_valid,
    input logic [ADDR_W-1:0] chan_addr,
    input logic [WORD_W-1:0] word_idx,
    input logic [BIT_W-1:0]  bit_idx,
    input logic              end_of_scan,
    input logic              port_match,
    input logic [ADDR_W-1:0] ovh_addr,
    input logic [N_CH-1:0]   gclk,
    input logic [ADDR_W-1:0] oh2_q,
    input stuff_act_e        pend_act
);

    logic ins_slot;
    always_comb ins_slot = (word_idx == WORD_W'(W_INS)) && (bit_idx == '0);

    a_r1_reset_quiet: assert property (@(posedge clk)
        !rst_n |=> (gclk == '0) && (ovh_addr == '0));

    a_r2_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(gclk));

    a_r3_idle_slot: assert property (@(posedge clk) disable iff (!rst_n)
        ((!slot_valid || chan_addr == '0) && !ins_slot) |=> gclk == '0);

    a_r4_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (end_of_scan && word_idx == WORD_W'(W_CLEAR)) |=> ovh_addr == '0);

    a_r5_load: assert property (@(posedge clk) disable iff (!rst_n)
        (port_match && word_idx == WORD_W'(W_LOAD)) |=> ovh_addr == $past(chan_addr));

    a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (word_idx != WORD_W'(W_LOAD) && !(end_of_scan && word_idx == WORD_W'(W_CLEAR)))
        |=> $stable(ovh_addr));

    a_r6_insert: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_act == ACT_INS && ins_slot) |=> $countones(gclk) == 1);

    a_r7_drop: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_act == ACT_DEL && slot_valid && chan_addr != '0 && chan_addr == oh2_q)
        |=> gclk == '0);

    a_r8_zero_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (end_of_scan && word_idx == WORD_W'(W_LOAD) && ovh_addr == '0)
        |=> pend_act == ACT_NONE);

endmodule

bind stuff_gclk_ctrl stuff_gclk_chk #(
    .ADDR_W(ADDR_W), .WORD_W(WORD_W), .BIT_W(BIT_W),
    .W_CLEAR(W_CLEAR), .W_LOAD(W_LOAD)
) i_chk (
    .clk(clk), .rst_n(rst_n), .slot_valid(slot_valid), .chan_addr(chan_addr),
    .word_idx(word_idx), .bit_idx(bit_idx), .end_of_scan(end_of_scan),
    .port_match(port_match), .ovh_addr(ovh_addr), .gclk(gclk),
    .oh2_q(oh2_q), .pend_act(pend_act)
);

// File: tb/test_stuff_gclk_ctrl.sv
`timescale 1ns/1ps
module test_stuff_gclk_ctrl;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        slot_valid;
    logic [3:0]  chan_addr;
    logic [4:0]  word_idx;
    logic [2:0]  bit_idx;
    logic        end_of_scan;
    logic        port_match;
    logic        pos_req;
    logic        neg_req;
    logic [3:0]  ovh_addr;
    logic [14:0] gclk;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    // Reference state, derived from the requirements.
    logic [3:0]  m_oh1 = '0;
    logic [3:0]  m_oh2 = '0;
    int          m_pend = 0;      // 0 none, 1 insert, 2 delete
    logic [14:0] exp_g  = '0;
    logic [3:0]  exp_o  = '0;
    string       tag_g  = "R3";
    string       tag_o  = "R5";

    always #2.5 clk = ~clk;

    stuff_gclk_ctrl i_stuff_gclk_ctrl (
        .clk(clk), .rst_n(rst_n), .slot_valid(slot_valid), .chan_addr(chan_addr),
        .word_idx(word_idx), .bit_idx(bit_idx), .end_of_scan(end_of_scan),
        .port_match(port_match), .pos_req(pos_req), .neg_req(neg_req),
        .ovh_addr(ovh_addr), .gclk(gclk)
    );

    function automatic logic [14:0] onehot_of(input logic [3:0] a);
        return (a == 4'd0) ? 15'd0 : (15'd1 << (a - 4'd1));
    endfunction

    task automatic check(input string tag, input logic [14:0] act, input logic [14:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Compute the expected outputs for the inputs now applied, then advance.
    task automatic model_step();
        logic ins_slot;
        ins_slot = (word_idx == 5'd29) && (bit_idx == 3'd0);
        if (m_pend == 1 && ins_slot) begin
            exp_g = onehot_of(m_oh2); tag_g = "R6"; m_pend = 0;
        end else if (slot_valid && chan_addr != 0) begin
            if (m_pend == 2 && chan_addr == m_oh2) begin
                exp_g = '0; tag_g = "R7"; m_pend = 0;
            end else begin
                exp_g = onehot_of(chan_addr);
                tag_g = ins_slot ? "R9" : "R2";
            end
        end else begin
            exp_g = '0; tag_g = "R3";
        end
        tag_o = "R5";
        if (end_of_scan && word_idx == 5'd28) begin
            if (m_oh1 == 0)   m_pend = 0;
            else if (pos_req) m_pend = 1;
            else if (neg_req) m_pend = 2;
            else              m_pend = 0;
            if (pos_req && neg_req) tag_g = "R8";
            m_oh2 = m_oh1;
        end
        if (end_of_scan && word_idx == 5'd27) begin
            m_oh1 = '0; tag_o = "R4";
        end else if (port_match && word_idx == 5'd28) begin
            m_oh1 = chan_addr;
        end
        exp_o = m_oh1;
    endtask

    // Drive one bit slot of a frame according to the frame mode.
    task automatic drive(input int w, input int b, input int mode);
        int r;
        word_idx    = 5'(w);
        bit_idx     = 3'(b);
        end_of_scan = (b == 7);
        slot_valid  = ($urandom % 4) != 0;
        chan_addr   = 4'($urandom % 16);
        port_match  = 1'b0;
        pos_req     = 1'($urandom % 2);
        neg_req     = 1'($urandom % 2);
        if (w == 28 && b == 3 && mode != 2)
            port_match = (mode != 0) || (($urandom % 4) != 0);
        if (mode == 3 && w == 10 && b == 3) port_match = 1'b1;   // R5 ignored
        if (port_match && w == 28 && mode == 4) chan_addr = 4'd5;
        if (port_match && w == 28 && mode == 5) chan_addr = 4'd9;
        if (w == 29 && b == 0) slot_valid = 1'b1;
        if (w == 28 && b == 7) begin
            r = $urandom % 3;
            pos_req = (ovh_addr != 0) && (r == 1);
            neg_req = (ovh_addr != 0) && (r == 2);
            if (mode == 1 || mode == 2) begin pos_req = 1'b1; neg_req = 1'b1; end
            if (mode == 4) begin pos_req = 1'b1; neg_req = 1'b0; end
            if (mode == 5) begin pos_req = 1'b0; neg_req = 1'b1; end
        end
        if (mode == 5 && w == 30 && b == 2) begin slot_valid = 1'b1; chan_addr = 4'd9; end
        if (mode == 5 && w == 30 && b == 5) begin slot_valid = 1'b1; chan_addr = 4'd9; end
    endtask

    initial begin
        void'($urandom(32'd4711));
        rst_n = 1'b0; slot_valid = 1'b1; chan_addr = 4'd3; word_idx = 5'd27;
        bit_idx = 3'd7; end_of_scan = 1'b1; port_match = 1'b1;
        pos_req = 1'b1; neg_req = 1'b0;
        repeat (4) @(negedge clk);
        check("R1", gclk, 15'd0);
        check("R1", 15'(ovh_addr), 15'd0);
        rst_n = 1'b1;
        for (int f = 0; f < 40; f++) begin
            int mode;
            mode = (f >= 1 && f <= 5) ? f : 0;
            for (int w = 0; w < 32; w++) begin
                for (int b = 0; b < 8; b++) begin
                    drive(w, b, mode);
                    model_step();
                    @(negedge clk);
                    check(tag_g, gclk, exp_g);
                    check(tag_o, 15'(ovh_addr), 15'(exp_o));
                end
            end
        end
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

endmodule